// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

The block receives frames on a single serial line that rests at 1 between frames. Each frame is a 0 start bit, eight data bits sent least-significant first, a parity bit and a 1 stop bit. A tick input that pulses sixteen times per bit period sets the timing. The receiver checks each start bit at its midpoint. It then samples every later bit once at that bit's midpoint, assembles the byte in a shift register, and checks the parity and the stop bit when the frame ends.

A finished byte goes into a holding register. Four status flags report what happened: a full flag, plus overrun, parity-error and framing-error flags. A host reads the byte with a read strobe, which also clears the full flag, and clears each error flag with its own strobe. Two level interrupt requests, one for data and one for errors, share a single enable input.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, rxData is 0, all four flags are 0 and both interrupt outputs are 0.
- R2: An error-free frame whose data bits are sent least-significant bit first loads the byte into rxData and sets rxFull to 1.
- R3: A low pulse on the line that ends before the midpoint of a start bit (fewer than 8 of 16 ticks) starts no frame. The receiver returns to idle and takes the next real frame correctly.
- R4: With the default even parity, the data bits and the parity bit together hold an even number of ones. A frame that breaks this rule sets parityErr and still loads the byte into rxData, and rxFull is not set by it.
- R5: A frame whose stop bit is sampled as 0 sets framingErr and still loads the byte into rxData, and rxFull is not set by it. No new start bit is detected until the line has returned to 1.
- R6: A frame that completes while rxFull is 1 sets overrunErr. rxData keeps the earlier byte and rxFull stays 1.
- R7: A one-cycle pulse on hostRead clears rxFull. Pulses on clrOverrun, clrParity and clrFraming each clear their own flag.
- R8: An error flag stays set until its own clear strobe. A later error-free frame does not clear it.
- R9: rxIrq equals rxFull AND irqEn. errIrq equals (overrunErr OR parityErr OR framingErr) AND irqEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversample tick, 16 per bit period |
| rxLine | input | 1 | Serial input line, idles at 1 |
| irqEn | input | 1 | Enable for both interrupt requests |
| hostRead | input | 1 | Read strobe; clears rxFull |
| clrOverrun | input | 1 | Clears overrunErr |
| clrParity | input | 1 | Clears parityErr |
| clrFraming | input | 1 | Clears framingErr |
| rxData | output | 8 | Receive holding register |
| rxFull | output | 1 | Holding register has unread good data |
| overrunErr | output | 1 | Overrun flag |
| parityErr | output | 1 | Parity error flag |
| framingErr | output | 1 | Framing error flag |
| rxIrq | output | 1 | Receive interrupt request (level) |
| errIrq | output | 1 | Error interrupt request (level) |

## Verification
Most wrong internal states show at the ports within one frame time after the stop-bit midpoint. A bit counter or tick counter that is off by one shows up as a shifted or rotated byte in rxData, or as a false parity or framing error. Wrong overrun handling shows as a replaced byte or a dropped rxFull once a second frame has arrived. A flag that clears too easily shows only after a later good frame, so the bench sends good frames after each error before it checks the flags.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_WAITHIGH
  } rxState_t;

  typedef struct packed {
    logic shiftData;
    logic takeParity;
    logic frameDone;
    logic stopBad;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxSync,
  output rxStrobe_t strobe
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic          atBitEnd;

  assign atBitEnd = tick && (tickCnt == LAST_TICK);

  always_comb begin
    strobe = '0;
    case (state)
      ST_DATA:   strobe.shiftData  = atBitEnd;
      ST_PARITY: strobe.takeParity = atBitEnd;
      ST_STOP: begin
        strobe.frameDone = atBitEnd;
        strobe.stopBad   = atBitEnd && !rxSync;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick && !rxSync) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == MID_TICK) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxSync ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (bitIdx == LAST_BIT) state <= ST_PARITY;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atBitEnd) begin
            tickCnt <= '0;
            state   <= rxSync ? ST_IDLE : ST_WAITHIGH;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_WAITHIGH: begin
          if (rxSync) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftData, strobe.takeParity, strobe.frameDone}));

  // R5
  wait_high_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITHIGH && !rxSync) |=> (state == ST_WAITHIGH));
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  input  logic                 hostRead,
  input  logic                 clrOverrun,
  input  logic                 clrParity,
  input  logic                 clrFraming,
  output logic                 rxSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 overrunErr,
  output logic                 parityErr,
  output logic                 framingErr
);
  logic                 syncMeta;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parityBit;
  logic                 parityBad;
  logic                 fullHeld;

  assign parityBad = ((^shiftReg) ^ parityBit) != ODD_PARITY;
  assign fullHeld  = rxFull && !hostRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b1;
      rxSync   <= 1'b1;
    end else begin
      syncMeta <= rxLine;
      rxSync   <= syncMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.shiftData)  shiftReg  <= {rxSync, shiftReg[DATA_BITS-1:1]};
      if (strobe.takeParity) parityBit <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxFull     <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      if (hostRead)   rxFull     <= 1'b0;
      if (clrOverrun) overrunErr <= 1'b0;
      if (clrParity)  parityErr  <= 1'b0;
      if (clrFraming) framingErr <= 1'b0;
      if (strobe.frameDone) begin
        if (fullHeld) begin
          overrunErr <= 1'b1;
        end else begin
          rxData <= shiftReg;
          if (parityBad)      parityErr  <= 1'b1;
          if (strobe.stopBad) framingErr <= 1'b1;
          if (!parityBad && !strobe.stopBad) rxFull <= 1'b1;
        end
      end
    end
  end

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && rxFull && !hostRead)
      |=> (overrunErr && rxFull && $stable(rxData)));

  // R4
  parity_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && !rxFull && parityBad)
      |=> (parityErr && rxData == $past(shiftReg)));

  // R8
  framing_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr && !clrFraming) |=> framingErr);
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 irqEn,
  input  logic                 hostRead,
  input  logic                 clrOverrun,
  input  logic                 clrParity,
  input  logic                 clrFraming,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 overrunErr,
  output logic                 parityErr,
  output logic                 framingErr,
  output logic                 rxIrq,
  output logic                 errIrq
);
  rxStrobe_t strobe;
  logic      rxSync;

  serial_rx_ctrl #(
    .DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .rxSync(rxSync), .strobe(strobe)
  );

  serial_rx_datapath #(
    .DATA_BITS(DATA_BITS), .ODD_PARITY(ODD_PARITY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(strobe),
    .hostRead(hostRead), .clrOverrun(clrOverrun), .clrParity(clrParity),
    .clrFraming(clrFraming), .rxSync(rxSync), .rxData(rxData), .rxFull(rxFull),
    .overrunErr(overrunErr), .parityErr(parityErr), .framingErr(framingErr)
  );

  assign rxIrq  = rxFull && irqEn;
  assign errIrq = (overrunErr || parityErr || framingErr) && irqEn;
endmodule

// File: tb/tb_serial_rx_top.sv
module tb_serial_rx_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       irqEn = 1'b0;
  logic       hostRead = 1'b0;
  logic       clrOverrun = 1'b0;
  logic       clrParity = 1'b0;
  logic       clrFraming = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, overrunErr, parityErr, framingErr, rxIrq, errIrq;

  int testsRun = 0;
  int testsFailed = 0;
  int tickCount = 0;

  serial_rx_top dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .irqEn(irqEn), .hostRead(hostRead), .clrOverrun(clrOverrun),
    .clrParity(clrParity), .clrFraming(clrFraming), .rxData(rxData),
    .rxFull(rxFull), .overrunErr(overrunErr), .parityErr(parityErr),
    .framingErr(framingErr), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tickCount  <= (tickCount == TICK_DIV - 1) ? 0 : tickCount + 1;
    sampleTick <= (tickCount == TICK_DIV - 1);
  end

  // data, flipParity, badStop
  typedef struct packed {
    logic [7:0] data;
    logic       flipPar;
    logic       badStop;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h55, 1'b0, 1'b0}, '{8'hA3, 1'b0, 1'b0}, '{8'h00, 1'b0, 1'b0},
    '{8'hFF, 1'b0, 1'b0}, '{8'h3C, 1'b1, 1'b0}, '{8'h81, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk);
    hostRead = 1'b1; clrOverrun = 1'b1; clrParity = 1'b1; clrFraming = 1'b1;
    @(negedge clk);
    hostRead = 1'b0; clrOverrun = 1'b0; clrParity = 1'b0; clrFraming = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxLine = b;
    waitClks(BIT_CLKS - 1);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic flipPar, input logic badStop);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit((^d) ^ flipPar);
    sendBit(!badStop);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    waitClks(4);
    // R1 reset state
    check("R1 rxData", rxData, 0);
    check("R1 flags", {rxFull, overrunErr, parityErr, framingErr}, 0);
    check("R1 irqs", {rxIrq, errIrq}, 0);
    @(negedge clk); rstN = 1'b1;
    waitClks(BIT_CLKS);

    // table walk: R2 good frames, R4 parity error, R5 framing error
    for (int v = 0; v < 6; v++) begin
      clearAll();
      sendFrame(VECS[v].data, VECS[v].flipPar, VECS[v].badStop);
      check("R2 R4 R5 rxData", rxData, VECS[v].data);
      check("R2 rxFull", rxFull, !VECS[v].flipPar && !VECS[v].badStop);
      check("R4 parityErr", parityErr, VECS[v].flipPar);
      check("R5 framingErr", framingErr, VECS[v].badStop);
      check("R9 irq gated off", {rxIrq, errIrq}, 0);
    end

    // R9 interrupt enable
    irqEn = 1'b1;
    waitClks(2);
    check("R9 errIrq on framing", errIrq, 1);
    check("R9 rxIrq no full", rxIrq, 0);

    // R8 sticky framing flag across good frame
    sendFrame(8'h6E, 1'b0, 1'b0);
    check("R8 framingErr sticky", framingErr, 1);
    check("R2 rxData after error", rxData, 8'h6E);
    check("R9 rxIrq full", rxIrq, 1);

    // R7 clear strobes
    pulse(clrFraming);
    waitClks(1);
    check("R7 clrFraming", framingErr, 0);
    check("R9 errIrq off", errIrq, 0);
    pulse(hostRead);
    waitClks(1);
    check("R7 hostRead clears full", rxFull, 0);

    // R6 overrun
    clearAll();
    sendFrame(8'h12, 1'b0, 1'b0);
    sendFrame(8'h34, 1'b0, 1'b0);
    check("R6 rxData kept", rxData, 8'h12);
    check("R6 rxFull kept", rxFull, 1);
    check("R6 overrunErr", overrunErr, 1);
    check("R9 errIrq overrun", errIrq, 1);
    pulse(clrOverrun);
    waitClks(1);
    check("R7 clrOverrun", overrunErr, 0);

    // R3 short low glitch ignored
    clearAll();
    @(negedge clk); rxLine = 1'b0;
    waitClks(3 * TICK_DIV);
    @(negedge clk); rxLine = 1'b1;
    waitClks(3 * BIT_CLKS);
    check("R3 glitch no data", {rxFull, parityErr, framingErr}, 0);
    sendFrame(8'hC9, 1'b0, 1'b0);
    check("R3 next frame data", rxData, 8'hC9);
    check("R3 next frame full", rxFull, 1);

    // R5 held low after bad stop: no new frame until line high
    clearAll();
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b0);
    waitClks(12 * BIT_CLKS);
    check("R5 framingErr low line", framingErr, 1);
    check("R5 only one frame", {rxFull, overrunErr}, 0);
    @(negedge clk); rxLine = 1'b1;
    waitClks(2 * BIT_CLKS);
    sendFrame(8'h5A, 1'b0, 1'b0);
    check("R5 recovers after high", rxData, 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule